// File: doc/BRIEF.md
# Prescaled 8-bit Timer/Counter

This block is an 8-bit up-counter that software loads and reads through a plain write/read port. It counts either instruction-cycle ticks (timer mode) or edges of an external clock pin (counter mode). The pin is resampled on instruction ticks through a two-stage synchronizer, and the active edge is selectable. A power-of-two prescaler with a 3-bit ratio field can sit in the count path or be bypassed. When the count rolls from FFh to 00h, a sticky overflow flag is raised, and it stays up until software clears it.

A write to the count register loads the new value and clears the prescaler's accumulated ticks. It also holds off counting for the next two instruction ticks, so software that wants exact timing writes a value pre-adjusted for that gap. No streaming data crosses the block's edge, so there is no valid/ready handshake and no back-pressure. Every pin is a plain level or single-cycle strobe sampled on the system clock. Reset is synchronous, active high, and clears all state to zero.

Top module: `tmr8_timer`

## Requirements
- R1: While `rst` is high at a clock edge, the count and the overflow flag become 0 after that edge.
- R2: In timer mode (`cfg_src_ext`=0) with the prescaler bypassed (`cfg_pre_bypass`=1), the count rises by exactly 1 on each clock where `cyc_en` is high. It does not change on clocks where `cyc_en` is low.
- R3: A clock with `cnt_wr` high loads `cnt_wdata` into the count, whatever else happens in that clock. The next two `cyc_en` ticks cause no increment, and the third tick counts normally.
- R4: In counter mode with `cfg_edge_fall`=0, a rising edge of `ext_clk` counts once. The pin is sampled on `cyc_en` ticks. If the new level is first sampled on tick k, the count rises at tick k+2. A falling edge is not counted.
- R5: In counter mode with `cfg_edge_fall`=1, only falling edges count, with the same two-tick delay as R4. Rising edges are ignored.
- R6: With `cfg_pre_bypass`=0, the count rises once per 2^(`cfg_pre_sel`+1) accepted source ticks, counted from the last count write. Field value 0 gives 1:2, 3 gives 1:16, and 7 gives 1:256.
- R7: A count write discards the prescaler's partial progress. After the write's two inhibited ticks, a full prescaler period is needed before the next increment.
- R8: An increment from FFh to 00h sets `ovf_flag`. The flag then stays set while `ovf_clr` is low.
- R9: `ovf_clr` high clears the flag at the next edge. If an FFh-to-00h wrap happens in that same clock, the flag ends up set.
- R10: In counter mode, `cyc_en` ticks without a qualifying pin edge leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_en | input | 1 | One-clock instruction-cycle tick |
| cfg_src_ext | input | 1 | 0 = count instruction ticks, 1 = count pin edges |
| cfg_edge_fall | input | 1 | 0 = rising pin edge counts, 1 = falling edge counts |
| cfg_pre_bypass | input | 1 | 0 = prescaler in path, 1 = prescaler bypassed |
| cfg_pre_sel | input | 3 | Prescaler ratio field, ratio 2^(field+1) |
| cnt_wr | input | 1 | Count register write strobe |
| cnt_wdata | input | 8 | Count register write value |
| cnt_rdata | output | 8 | Current count |
| ext_clk | input | 1 | External count pin |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_clr | input | 1 | Software clear for the overflow flag |

## Verification
The hardest case to reach from the ports is a flag clear that lands in the very clock of an FFh-to-00h wrap. The write inhibit, the prescaler phase and the sparse instruction ticks all move the wrap in time. The stimulus reaches this case by loading FFh and spending the two inhibited ticks. It then raises the clear together with the third tick, and it first forces a prior wrap so the flag is already set.

Pin edges are a second hard case, because they take effect two samples after they appear. Level changes are therefore held across several ticks in each edge mode. A long randomized run then mixes writes, clears, configuration changes and pin toggling against the cycle-level reference model.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

  localparam int unsigned CNT_W       = 8;
  localparam int unsigned PS_SEL_W    = 3;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned WR_HOLD     = 2;

  typedef struct packed {
    logic                src_ext;
    logic                edge_fall;
    logic                pre_bypass;
    logic [PS_SEL_W-1:0] pre_sel;
  } tmr_cfg_t;

endpackage

// File: rtl/tmr8_edge_sync.sv
module tmr8_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic smp_en,
  input  logic pin_i,
  input  logic fall_sel,
  output logic edge_o
);

  localparam int unsigned LEN = STAGES + 1;

  logic [LEN-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q[0] <= 1'b0;
    else if (smp_en) sh_q[0] <= pin_i;
  end

  generate
    for (genvar i = 1; i < LEN; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) sh_q[i] <= 1'b0;
        else if (smp_en) sh_q[i] <= sh_q[i-1];
      end
    end
  endgenerate

  logic lvl_now, lvl_old;
  assign lvl_now = sh_q[STAGES-1];
  assign lvl_old = sh_q[STAGES];

  always_comb begin
    if (fall_sel) edge_o = smp_en & lvl_old & ~lvl_now;
    else          edge_o = smp_en & ~lvl_old & lvl_now;
  end

endmodule

// File: rtl/tmr8_prescaler.sv
module tmr8_prescaler #(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tick_i,
  input  logic             bypass,
  input  logic [SEL_W-1:0] sel,
  output logic             tick_o
);

  localparam int unsigned PS_W = 1 << SEL_W;

  logic [PS_W-1:0] acc_q;
  logic [PS_W-1:0] mask;
  logic            hit;

  generate
    for (genvar i = 0; i < PS_W; i++) begin : g_mask
      assign mask[i] = (sel >= SEL_W'(i));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clr) acc_q <= '0;
    else if (tick_i) acc_q <= acc_q + 1'b1;
  end

  assign hit    = ((acc_q & mask) == mask);
  assign tick_o = tick_i & (bypass | hit);

endmodule

// File: rtl/tmr8_write_guard.sv
module tmr8_write_guard #(
  parameter int unsigned HOLD = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  logic cyc_en,
  output logic blocked
);

  localparam int unsigned GW = $clog2(HOLD + 1);

  logic [GW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) left_q <= '0;
    else if (wr) left_q <= GW'(HOLD);
    else if (cyc_en && (left_q != '0)) left_q <= left_q - 1'b1;
  end

  assign blocked = (left_q != '0);

endmodule

// File: rtl/tmr8_count_reg.sv
module tmr8_count_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         inc,
  input  logic         flag_clr,
  output logic [W-1:0] cnt_o,
  output logic         flag_o
);

  logic [W-1:0] cnt_q;
  logic         flag_q;
  logic         wrap;

  assign wrap = inc & ~wr & (cnt_q == {W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (wr) cnt_q <= wdata;
    else if (inc) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else flag_q <= wrap | (flag_q & ~flag_clr);
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;

endmodule

// File: rtl/tmr8_timer.sv
module tmr8_timer
  import tmr8_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                cyc_en,
  input  logic                cfg_src_ext,
  input  logic                cfg_edge_fall,
  input  logic                cfg_pre_bypass,
  input  logic [PS_SEL_W-1:0] cfg_pre_sel,
  input  logic                cnt_wr,
  input  logic [CNT_W-1:0]    cnt_wdata,
  output logic [CNT_W-1:0]    cnt_rdata,
  input  logic                ext_clk,
  output logic                ovf_flag,
  input  logic                ovf_clr
);

  tmr_cfg_t cfg;
  assign cfg = '{src_ext: cfg_src_ext, edge_fall: cfg_edge_fall,
                 pre_bypass: cfg_pre_bypass, pre_sel: cfg_pre_sel};

  logic pin_edge, src_tick, hold_off, gated_tick, cnt_inc;

  tmr8_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .smp_en(cyc_en), .pin_i(ext_clk),
    .fall_sel(cfg.edge_fall), .edge_o(pin_edge)
  );

  tmr8_write_guard #(.HOLD(WR_HOLD)) u_guard (
    .clk(clk), .rst(rst), .wr(cnt_wr), .cyc_en(cyc_en), .blocked(hold_off)
  );

  assign src_tick   = cfg.src_ext ? pin_edge : cyc_en;
  assign gated_tick = src_tick & ~hold_off & ~cnt_wr;

  tmr8_prescaler #(.SEL_W(PS_SEL_W)) u_pre (
    .clk(clk), .rst(rst), .clr(cnt_wr), .tick_i(gated_tick),
    .bypass(cfg.pre_bypass), .sel(cfg.pre_sel), .tick_o(cnt_inc)
  );

  tmr8_count_reg #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .wr(cnt_wr), .wdata(cnt_wdata), .inc(cnt_inc),
    .flag_clr(ovf_clr), .cnt_o(cnt_rdata), .flag_o(ovf_flag)
  );

endmodule

// File: rtl/tmr8_timer_chk.sv
module tmr8_timer_chk (
  input logic       clk,
  input logic       rst,
  input logic       cyc_en,
  input logic       cnt_wr,
  input logic [7:0] cnt_wdata,
  input logic [7:0] cnt_rdata,
  input logic       ovf_flag,
  input logic       ovf_clr
);

  // ticks seen since the last write, saturating at 3
  logic [1:0] since_wr;
  always_ff @(posedge clk) begin
    if (rst) since_wr <= 2'd3;
    else if (cnt_wr) since_wr <= 2'd0;
    else if (cyc_en && since_wr != 2'd3) since_wr <= since_wr + 2'd1;
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (cnt_rdata == 8'd0 && !ovf_flag));

  a_r2_no_tick_no_move: assert property (@(posedge clk) disable iff (rst)
    (!cnt_wr && !cyc_en) |=> $stable(cnt_rdata));

  a_r2_step_one: assert property (@(posedge clk) disable iff (rst)
    !cnt_wr |=> (cnt_rdata == $past(cnt_rdata) || cnt_rdata == $past(cnt_rdata) + 8'd1));

  a_r3_load: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> cnt_rdata == $past(cnt_wdata));

  a_r3_inhibit: assert property (@(posedge clk) disable iff (rst)
    (!cnt_wr && cyc_en && since_wr < 2'd2) |=> $stable(cnt_rdata));

  a_r8_wrap_sets: assert property (@(posedge clk) disable iff (rst)
    ($past(!cnt_wr) && $past(cnt_rdata) == 8'hFF && cnt_rdata == 8'h00) |-> ovf_flag);

  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

  a_r9_rise_only_on_wrap: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_flag) |-> ($past(cnt_rdata) == 8'hFF && cnt_rdata == 8'h00));

endmodule

bind tmr8_timer tmr8_timer_chk u_chk (
  .clk(clk), .rst(rst), .cyc_en(cyc_en), .cnt_wr(cnt_wr),
  .cnt_wdata(cnt_wdata), .cnt_rdata(cnt_rdata), .ovf_flag(ovf_flag),
  .ovf_clr(ovf_clr)
);

// File: tb/tb_tmr8_timer.sv
module tb_tmr8_timer;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cyc_en = 1'b0;
  logic       cfg_src_ext = 1'b0;
  logic       cfg_edge_fall = 1'b0;
  logic       cfg_pre_bypass = 1'b1;
  logic [2:0] cfg_pre_sel = 3'd0;
  logic       cnt_wr = 1'b0;
  logic [7:0] cnt_wdata = 8'd0;
  logic [7:0] cnt_rdata;
  logic       ext_clk = 1'b0;
  logic       ovf_flag;
  logic       ovf_clr = 1'b0;

  always #2.5 clk = ~clk;

  tmr8_timer dut (
    .clk(clk), .rst(rst), .cyc_en(cyc_en), .cfg_src_ext(cfg_src_ext),
    .cfg_edge_fall(cfg_edge_fall), .cfg_pre_bypass(cfg_pre_bypass),
    .cfg_pre_sel(cfg_pre_sel), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .cnt_rdata(cnt_rdata), .ext_clk(ext_clk), .ovf_flag(ovf_flag),
    .ovf_clr(ovf_clr)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    cmp_on  = 1'b0;
  bit    done    = 1'b0;
  string phase   = "R1";

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_cnt, m_pre, m_inh;
  bit m_flag, m_edge, m_src, m_go, m_wrap;
  bit hist[$];

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_pre = 0; m_inh = 0; m_flag = 0;
      hist = '{0, 0, 0};
    end else begin
      if (cfg_edge_fall) m_edge = cyc_en && hist[2] && !hist[1];
      else               m_edge = cyc_en && !hist[2] && hist[1];
      m_src  = cfg_src_ext ? m_edge : cyc_en;
      m_go   = m_src && (m_inh == 0) && !cnt_wr;
      m_wrap = 0;
      if (cyc_en) begin
        hist.push_front(ext_clk);
        void'(hist.pop_back());
      end
      if (cnt_wr) begin
        m_cnt = cnt_wdata; m_pre = 0; m_inh = 2;
      end else begin
        if (cyc_en && m_inh > 0) m_inh--;
        if (m_go) begin
          m_pre = (m_pre + 1) % 256;
          if (cfg_pre_bypass || (m_pre % (1 << (cfg_pre_sel + 1))) == 0) begin
            if (m_cnt == 255) m_wrap = 1;
            m_cnt = (m_cnt + 1) % 256;
          end
        end
      end
      m_flag = m_wrap || (m_flag && !ovf_clr);
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      check({phase, " model count"}, int'(cnt_rdata), m_cnt);
      check({phase, " model flag"}, int'(ovf_flag), int'(m_flag));
    end
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cyc_en = 1'b1;
      @(negedge clk); cyc_en = 1'b0;
    end
  endtask

  task automatic wr(int v);
    @(negedge clk); cnt_wr = 1'b1; cnt_wdata = 8'(v);
    @(negedge clk); cnt_wr = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    cmp_on = 1'b1;
    // R1 reset state
    check("R1 count after reset", int'(cnt_rdata), 0);
    check("R1 flag after reset", int'(ovf_flag), 0);

    // R2 timer mode, bypassed
    phase = "R2";
    tick(5);
    check("R2 five ticks", int'(cnt_rdata), 5);
    repeat (6) @(negedge clk);
    check("R2 idle no change", int'(cnt_rdata), 5);

    // R3 write and inhibit
    phase = "R3";
    wr(8'h10);
    check("R3 load", int'(cnt_rdata), 8'h10);
    tick(2);
    check("R3 two inhibited ticks", int'(cnt_rdata), 8'h10);
    tick(1);
    check("R3 third tick counts", int'(cnt_rdata), 8'h11);

    // R6 prescaler 1:8
    phase = "R6";
    cfg_pre_bypass = 1'b0; cfg_pre_sel = 3'd2;
    wr(0); tick(2);
    tick(7);
    check("R6 1:8 before period", int'(cnt_rdata), 0);
    tick(1);
    check("R6 1:8 at period", int'(cnt_rdata), 1);
    // R6 prescaler 1:256
    cfg_pre_sel = 3'd7;
    wr(0); tick(2);
    tick(255);
    check("R6 1:256 before period", int'(cnt_rdata), 0);
    tick(1);
    check("R6 1:256 at period", int'(cnt_rdata), 1);

    // R7 write discards prescaler progress
    phase = "R7";
    cfg_pre_sel = 3'd1;
    wr(8'h20); tick(2); tick(3);
    wr(8'h20); tick(2); tick(3);
    check("R7 partial progress discarded", int'(cnt_rdata), 8'h20);
    tick(1);
    check("R7 full period after write", int'(cnt_rdata), 8'h21);

    // R4 rising edge counter mode
    phase = "R4";
    cfg_pre_bypass = 1'b1; cfg_src_ext = 1'b1; cfg_edge_fall = 1'b0; ext_clk = 1'b0;
    tick(4);
    wr(0); tick(2);
    ext_clk = 1'b1;
    tick(2);
    check("R4 edge not yet counted", int'(cnt_rdata), 0);
    tick(1);
    check("R4 rising edge counted at k+2", int'(cnt_rdata), 1);
    phase = "R10";
    tick(4);
    check("R10 steady pin ignored", int'(cnt_rdata), 1);
    phase = "R4";
    ext_clk = 1'b0;
    tick(4);
    check("R4 falling edge ignored", int'(cnt_rdata), 1);

    // R5 falling edge
    phase = "R5";
    cfg_edge_fall = 1'b1;
    ext_clk = 1'b1;
    tick(4);
    check("R5 rising edge ignored", int'(cnt_rdata), 1);
    ext_clk = 1'b0;
    tick(2);
    check("R5 falling not yet counted", int'(cnt_rdata), 1);
    tick(1);
    check("R5 falling edge counted", int'(cnt_rdata), 2);

    // R8 overflow
    phase = "R8";
    cfg_src_ext = 1'b0;
    wr(8'hFD); tick(2); tick(2);
    check("R8 at FF", int'(cnt_rdata), 8'hFF);
    check("R8 flag low before wrap", int'(ovf_flag), 0);
    tick(1);
    check("R8 wrapped to 00", int'(cnt_rdata), 0);
    check("R8 flag set on wrap", int'(ovf_flag), 1);
    tick(3);
    check("R8 flag sticky", int'(ovf_flag), 1);

    // R9 clear racing with overflow
    phase = "R9";
    wr(8'hFF); tick(2);
    @(negedge clk); cyc_en = 1'b1; ovf_clr = 1'b1;
    @(negedge clk); cyc_en = 1'b0; ovf_clr = 1'b0;
    check("R9 wrap beats clear", int'(ovf_flag), 1);
    @(negedge clk); ovf_clr = 1'b1;
    @(negedge clk); ovf_clr = 1'b0;
    check("R9 clear alone", int'(ovf_flag), 0);

    // mixed random run against the model
    phase = "R6 mixed";
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      cyc_en  = ($urandom % 3) == 0;
      cnt_wr  = ($urandom % 60) == 0;
      cnt_wdata = 8'($urandom);
      ovf_clr = ($urandom % 40) == 0;
      if (($urandom % 5) == 0) ext_clk = ~ext_clk;
      if (($urandom % 150) == 0) begin
        cfg_src_ext    = 1'($urandom);
        cfg_edge_fall  = 1'($urandom);
        cfg_pre_bypass = 1'($urandom);
        cfg_pre_sel    = 3'($urandom % 3);
      end
    end
    @(negedge clk);
    cyc_en = 1'b0; cnt_wr = 1'b0; ovf_clr = 1'b0;

    // R1 reset mid-run
    phase = "R1";
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R1 count after mid-run reset", int'(cnt_rdata), 0);
    check("R1 flag after mid-run reset", int'(ovf_flag), 0);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule